// File: doc/BRIEF.md
# Serviced Watchdog Timer with Fixed-Length Reset Pulse

This block supervises a host processor. It runs from the fast system clock but counts time through a slow clock-enable input that pulses at the 32.768 kHz rate. The enables are divided into a free-running tick with a 250 ms period. Once software has set the enable bit through a write to the control address, the host must write to a separate service address often enough. If three ticks pass with no service, the block raises its reset output for exactly one further tick period, 250 ms.

The tick divider is never restarted by a service, so the last service can fall anywhere within a tick period. Expiry therefore happens between two and three tick periods after the last service, which is 500 to 750 ms at the default settings. A service clears only the count of elapsed ticks. Disabling the watchdog clears that count but lets a running reset pulse finish. While the pulse is active, services are ignored and the count stays at zero. When the pulse ends the count starts again from zero, so a host that stays silent gets a pulse every fourth tick.

The host side is a single-cycle write strobe with an address and one data bit. Only the control address and the service address are decoded.

Top module: `svc_watchdog`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the reset output is low and the watchdog is disabled.
- R2: A write (host_wr high) to the control address (parameter CTRL_ADDR, default 0x0A) loads ctrl_bit into the enable bit: 1 enables and 0 disables. The new value applies from the next clock cycle.
- R3: While the watchdog is disabled, no new reset pulse starts, however long the host stays silent.
- R4: A write to the service address (parameter KICK_ADDR, default 0x0B) clears the elapsed-tick count. Services spaced no more than two tick periods apart keep the reset output low indefinitely.
- R5: With the watchdog enabled and no service, the reset output rises one clock after the third tick that follows the last service or enable. This is between 2 and 3 tick periods after it.
- R6: The tick divider runs freely from reset and a service does not restart it. The delay from a service to expiry depends on where the service falls within the tick period.
- R7: A reset pulse lasts exactly PULSE_TICKS tick periods, which is PULSE_TICKS*TICK_DIV slow enables (default 1 x 8192). It starts and ends on tick boundaries.
- R8: Disabling the watchdog during a reset pulse does not shorten the pulse. Disabling clears the elapsed-tick count, so a later enable gets a full 2-to-3-tick window.
- R9: A service during a reset pulse changes neither the pulse length nor the time of the next expiry.
- R10: When a pulse ends and the watchdog is still enabled, the tick count restarts from zero. With no service, the next pulse begins exactly TIMEOUT_TICKS tick periods after the previous one ended.
- R11: Writes to any other address change neither the enable bit nor the tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | ADDR_W | Host write address |
| ctrl_bit | input | 1 | Data bit loaded into the enable on a control write |
| rst_out | output | 1 | Active-high reset pulse to the reset pin driver |

## Verification
On every cycle, the embedded assertions check the following: a pulse starts and ends only on a tick, a disabled watchdog never starts a pulse, a service or an active pulse leaves the tick count at zero, the count stays within its range, and the divider wraps on each tick. Only the bench scenarios can show the timing relations that span many ticks. These are the 2-to-3-tick expiry window, its dependence on the divider phase, the exact pulse width, the fixed four-tick period between repeated pulses, and the full window after a disable and re-enable. The bench shows these by measuring intervals at the output and by comparing against a behavioural model on every clock.

// File: rtl/wdt_pkg.sv
// Package: shared types for the serviced watchdog.
// Assumes: only the decoder produces host_op_e; other modules use its outputs.
package wdt_pkg;

    // Kind of host access seen in the current cycle.
    typedef enum logic [1:0] {
        HOST_IDLE  = 2'd0,
        HOST_CTRL  = 2'd1,
        HOST_KICK  = 2'd2,
        HOST_OTHER = 2'd3
    } host_op_e;

endpackage

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Divides the slow clock enable into a one-cycle tick every TICK_DIV enables.
// Assumes: TICK_DIV >= 2. The divider is free-running and nothing but reset
// restarts it.
module wdt_prescaler #(
    parameter int TICK_DIV = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en_i,
    output logic tick_o
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             at_last;

    // Flag the final enable of each tick period.
    always_comb begin
        at_last = (pre_q == PRE_LAST);
        tick_o  = slow_en_i && at_last;
    end

    // Advance the divider on every slow enable and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (slow_en_i) begin
            pre_q <= at_last ? '0 : pre_q + PRE_W'(1);
        end
    end

    // R6: the divider wraps to zero right after each tick.
    assert_prescaler_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (pre_q == '0));

endmodule

// File: rtl/wdt_host_decode.sv
// Module: wdt_host_decode
// Decodes host writes into a control update or a service strobe and holds
// the enable bit.
// Assumes: one write per strobe cycle. If both addresses are set equal, the
// control decode wins.
module wdt_host_decode
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int CTRL_ADDR = 10,
    parameter int KICK_ADDR = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic              ctrl_bit_i,
    output logic              en_o,
    output logic              kick_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] KICK_A = ADDR_W'(KICK_ADDR);

    host_op_e op;
    logic     en_q;

    // Classify the current host access.
    always_comb begin
        if (!host_wr_i)                op = HOST_IDLE;
        else if (host_addr_i == CTRL_A) op = HOST_CTRL;
        else if (host_addr_i == KICK_A) op = HOST_KICK;
        else                            op = HOST_OTHER;
    end

    // Hold the enable bit and update it only on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (op == HOST_CTRL) begin
            en_q <= ctrl_bit_i;
        end
    end

    assign en_o   = en_q;
    assign kick_o = (op == HOST_KICK);

    // R11: the enable bit changes only in the cycle after a control write.
    assert_enable_only_by_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr_i && host_addr_i == CTRL_A) |=> $stable(en_q));

endmodule

// File: rtl/wdt_timeout.sv
// Module: wdt_timeout
// Counts ticks since the last service and signals expiry on the
// TIMEOUT_TICKS-th one.
// Assumes: TIMEOUT_TICKS >= 2. A service, a cleared enable or an active
// reset pulse each hold the count at zero. A service in a tick cycle wins.
module wdt_timeout #(
    parameter int TIMEOUT_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic kick_i,
    input  logic pulse_i,
    output logic expire_o
);
    localparam int TC_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TIMEOUT_TICKS - 1);

    logic [TC_W-1:0] tcnt_q;
    logic            hold;

    // Decide whether counting is suspended and whether this tick expires.
    always_comb begin
        hold     = !en_i || pulse_i || kick_i;
        expire_o = tick_i && !hold && (tcnt_q == TC_LAST);
    end

    // Count elapsed ticks and return to zero on hold or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q <= '0;
        end else if (hold || expire_o) begin
            tcnt_q <= '0;
        end else if (tick_i) begin
            tcnt_q <= tcnt_q + TC_W'(1);
        end
    end

    // R4: a service leaves the count at zero in the next cycle.
    assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (tcnt_q == '0));
    // R9: no ticks accumulate while a pulse is running.
    assert_hold_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> (tcnt_q == '0));
    // R5: the count never passes the last value before expiry.
    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt_q <= TC_LAST);

endmodule

// File: rtl/wdt_pulse.sv
// Module: wdt_pulse
// Produces the reset pulse. It starts on expiry and lasts PULSE_TICKS tick
// periods.
// Assumes: expire_i occurs only while no pulse is active. The pulse ignores
// the enable and service inputs by design.
module wdt_pulse #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic expire_i,
    output logic pulse_o
);
    localparam int PC_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_TICKS - 1);

    logic            pulse_q;
    logic [PC_W-1:0] pcnt_q;

    // Start on expiry, count ticks while active, stop after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            pcnt_q  <= '0;
        end else if (!pulse_q) begin
            pulse_q <= expire_i;
            pcnt_q  <= '0;
        end else if (tick_i) begin
            if (pcnt_q == PC_LAST) begin
                pulse_q <= 1'b0;
                pcnt_q  <= '0;
            end else begin
                pcnt_q <= pcnt_q + PC_W'(1);
            end
        end
    end

    assign pulse_o = pulse_q;

    // R5: a pulse begins only in the cycle after a tick.
    assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> $past(tick_i));
    // R7: a pulse ends only in the cycle after a tick.
    assert_fall_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_q) |-> $past(tick_i));
    // R7: the tick counter rests at zero between pulses.
    assert_counter_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_q |-> (pcnt_q == '0));

endmodule

// File: rtl/svc_watchdog.sv
// Module: svc_watchdog (top)
// Host-serviced watchdog. It has a free-running tick divider, a tick count
// since the last service, and a fixed-length reset pulse.
// Assumes: slow_en is a one-cycle pulse synchronous to clk. rst_out goes to
// an external pin driver.
module svc_watchdog #(
    parameter int ADDR_W        = 6,
    parameter int CTRL_ADDR     = 10,
    parameter int KICK_ADDR     = 11,
    parameter int TICK_DIV      = 8192,
    parameter int TIMEOUT_TICKS = 3,
    parameter int PULSE_TICKS   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              ctrl_bit,
    output logic              rst_out
);
    logic tick;
    logic en;
    logic kick;
    logic expire;
    logic pulse;

    wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .slow_en_i(slow_en), .tick_o(tick)
    );

    wdt_host_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .KICK_ADDR(KICK_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n), .host_wr_i(host_wr), .host_addr_i(host_addr),
        .ctrl_bit_i(ctrl_bit), .en_o(en), .kick_o(kick)
    );

    wdt_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .kick_i(kick),
        .pulse_i(pulse), .expire_o(expire)
    );

    wdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pls (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .expire_i(expire), .pulse_o(pulse)
    );

    assign rst_out = pulse;

    // R3: a disabled watchdog with no pulse running stays quiet.
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !rst_out) |=> !rst_out);
    // R8: turning the enable off never cuts a running pulse short.
    assert_pulse_survives_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out && !tick) |=> rst_out);

endmodule

// File: tb/svc_watchdog_tb.sv
// Bench: drives host writes and slow enables and measures intervals at
// rst_out. It compares rst_out against a behavioural model on every clock.
module svc_watchdog_tb_top;
    localparam int TD = 4;    // slow enables per tick
    localparam int SD = 3;    // clocks per slow enable
    localparam int TO = 3;    // ticks to expiry
    localparam int PT = 1;    // ticks per pulse
    localparam int P  = TD * SD;
    localparam logic [5:0] CTRL_A = 6'h0A;
    localparam logic [5:0] KICK_A = 6'h0B;
    localparam logic [5:0] JUNK_A = 6'h15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_en = 1'b0;
    logic host_wr = 1'b0;
    logic [5:0] host_addr = 6'h00;
    logic ctrl_bit = 1'b0;
    logic rst_out;

    int n_checks = 0;
    int n_fail = 0;
    int hi_cnt = 0;
    int cyc = 0;
    string tag = "R1";

    svc_watchdog #(.ADDR_W(6), .CTRL_ADDR(10), .KICK_ADDR(11), .TICK_DIV(TD),
                   .TIMEOUT_TICKS(TO), .PULSE_TICKS(PT)) dut_i (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .host_wr(host_wr),
        .host_addr(host_addr), .ctrl_bit(ctrl_bit), .rst_out(rst_out)
    );

    always #4 clk = ~clk;

    // Slow enable: one cycle in every SD, driven away from the active edge.
    int sdiv = 0;
    always @(negedge clk) begin
        sdiv = (sdiv + 1) % SD;
        slow_en <= (sdiv == 0);
    end

    // Behavioural reference model.
    int m_pre, m_cnt, m_pw;
    bit m_en, m_pulse, m_tick, m_kick, m_ctrl, m_fire, m_was;
    initial begin m_pre = 0; m_cnt = 0; m_pw = 0; m_en = 0; m_pulse = 0; end
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_pw = 0; m_en = 0; m_pulse = 0;
        end else begin
            m_tick = slow_en && (m_pre == TD - 1);
            m_kick = host_wr && (host_addr == KICK_A);
            m_ctrl = host_wr && (host_addr == CTRL_A);
            m_fire = m_tick && m_en && !m_pulse && !m_kick && (m_cnt == TO - 1);
            m_was  = m_pulse;
            if (m_pulse) begin
                if (m_tick) begin
                    m_pw++;
                    if (m_pw == PT) begin m_pulse = 0; m_pw = 0; end
                end
            end else if (m_fire) begin
                m_pulse = 1; m_pw = 0;
            end
            if (!m_en || m_was || m_kick || m_fire) m_cnt = 0;
            else if (m_tick) m_cnt++;
            if (m_ctrl) m_en = ctrl_bit;
            if (slow_en) m_pre = (m_pre + 1) % TD;
        end
    end

    // Every-cycle comparison with the model, plus a high-cycle counter.
    always @(negedge clk) begin
        cyc++;
        if (rst_out) hi_cnt++;
        n_checks++;
        if (rst_out !== m_pulse) begin
            n_fail++;
            $display("FAIL %s model compare cycle %0d: rst_out act=%b exp=%b", tag, cyc, rst_out, m_pulse);
        end
    end

    task automatic check(input bit ok, input string t, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0d exp=%0d", t, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [5:0] a, input logic b);
        host_wr = 1'b1; host_addr = a; ctrl_bit = b;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 6'h00; ctrl_bit = 1'b0;
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        while (!rst_out && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_width(input bit do_wr, input logic [5:0] a, input logic b, output int w);
        w = 0;
        if (do_wr) begin w = 1; host_write(a, b); end
        while (rst_out && w < 2000) begin w++; @(negedge clk); end
    endtask

    task automatic quiet_for(input int n, input string t);
        hi_cnt = 0;
        repeat (n) @(negedge clk);
        check(hi_cnt == 0, t, "reset cycles in quiet window", hi_cnt, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: act=hung exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n, w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check(rst_out == 1'b0, "R1", "rst_out after reset", rst_out, 0);

        tag = "R3";
        quiet_for(100, "R3");

        tag = "R11";
        host_write(JUNK_A, 1'b1);
        quiet_for(100, "R11");

        tag = "R2";
        host_write(CTRL_A, 1'b1);
        repeat (20) @(negedge clk);
        host_write(CTRL_A, 1'b0);
        quiet_for(100, "R2");

        tag = "R4";
        host_write(CTRL_A, 1'b1);
        hi_cnt = 0;
        for (int k = 0; k < 15; k++) begin
            repeat (19) @(negedge clk);
            host_write(KICK_A, 1'b0);
        end
        check(hi_cnt == 0, "R4", "reset cycles while serviced", hi_cnt, 0);

        tag = "R5";
        wait_rise(n);
        check(n >= 2*P + 1 && n <= 3*P, "R5", "service-to-expiry cycles", n, 2*P + 1);

        tag = "R7";
        pulse_width(1'b0, 6'h00, 1'b0, w);
        check(w == PT*P, "R7", "pulse width", w, PT*P);

        tag = "R10";
        wait_rise(n);
        check(n == TO*P, "R10", "pulse end to next pulse", n, TO*P);

        tag = "R9";
        pulse_width(1'b1, KICK_A, 1'b0, w);
        check(w == PT*P, "R9", "pulse width with service inside", w, PT*P);
        wait_rise(n);
        check(n == TO*P, "R9", "next expiry after service inside pulse", n, TO*P);

        tag = "R8";
        pulse_width(1'b1, CTRL_A, 1'b0, w);
        check(w == PT*P, "R8", "pulse width with disable inside", w, PT*P);
        quiet_for(100, "R8");
        host_write(CTRL_A, 1'b1);
        repeat (22) @(negedge clk);
        host_write(CTRL_A, 1'b0);
        host_write(CTRL_A, 1'b1);
        wait_rise(n);
        check(n >= 2*P + 1 && n <= 3*P, "R8", "full window after re-enable", n, 2*P + 1);
        pulse_width(1'b0, 6'h00, 1'b0, w);
        check(w == PT*P, "R7", "pulse width after re-enable", w, PT*P);

        tag = "R11";
        host_write(JUNK_A, 1'b0);
        wait_rise(n);
        check(n + 1 == TO*P, "R11", "junk write leaves enable and count", n + 1, TO*P);
        pulse_width(1'b0, 6'h00, 1'b0, w);
        check(w == PT*P, "R7", "pulse width repeated", w, PT*P);

        tag = "R6";
        repeat (10) @(negedge clk);
        host_write(KICK_A, 1'b0);
        wait_rise(n);
        check(n == 2*P + 1, "R6", "expiry with divider not restarted", n, 2*P + 1);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule